// File: doc/BRIEF.md
# Control-Pin Mode Entry Sequencer

This block watches the two control pins of a serial LED driver interface, the output-blanking pin and the latch pin, and recognises a mode-change handshake on them. A one-cycle strobe `step_i` marks each rising edge of the serial shift clock. On every strobe the block records the (blank, latch) pair. When the five most recent records form one of two fixed patterns, the operating mode changes. One pattern selects the special mode, in which neighbouring blocks handle brightness setting and fault checking. The other pattern selects the normal mode.

The block also holds the output data latch. In normal mode this latch follows the shift-register contents while the latch pin is high. The driven outputs are forced off while the blank pin is high. While a special-mode handshake is under way, the latch pin does not reach the latch. In special mode a high latch pin raises a load strobe for the neighbouring brightness register and leaves the output data alone. Every recognised return-to-normal handshake clears the output data, even when the block is already in normal mode.

The mode is held in a two-state machine. Its states are `MODE_NORMAL` and `MODE_SPECIAL`. The transitions are named as follows:
- ENTER: `MODE_NORMAL` to `MODE_SPECIAL`, on the special pattern.
- RETURN: `MODE_SPECIAL` to `MODE_NORMAL`, on the normal pattern, with a clear.
- REFRESH: `MODE_NORMAL` to `MODE_NORMAL`, on the normal pattern, with a clear only.
- HOLD: the state stays the same on any other step.

Top module: `led_mode_seq`

## Requirements
- R1: After reset, and whenever reset is applied, the block is in normal mode (`special_mode_o`=0), `latched_o` is 0 and `drive_o` is 0.
- R2: In normal mode, outside an entry guard, each clock with `latch_i`=1 loads `shift_data_i` into `latched_o`. The new value is visible after that clock edge.
- R3: `drive_o` equals `latched_o` while `enable_i`=0, and `drive_o` is all zero while `enable_i`=1. This path is combinational.
- R4: Five consecutive steps carrying (enable_i, latch_i) = (1,0), (0,0), (1,0), (1,1), (1,0), in that order, set `special_mode_o` to 1 after the edge of the fifth step. The special pattern and the normal pattern can never match on the same step.
- R5: In special mode, five consecutive steps carrying (1,0), (0,0), (1,0), (1,0), (1,0) return `special_mode_o` to 0 and clear `latched_o` to 0 at the edge of the fifth step.
- R6: The pattern of R5, when applied in normal mode, leaves the block in normal mode and still clears `latched_o` to 0.
- R7: When the three most recent steps were (1,0), (0,0), (1,0), the entry guard is active. While it is active, `latch_i`=1 does not change `latched_o`, and this includes the clock that carries the next step.
- R8: In special mode, `latch_i`=1 never changes `latched_o`. Outside the entry guard, `bright_load_o` is 1 on each such clock. `bright_load_o` is 0 in normal mode.
- R9: Only clocks with `step_i`=1 record samples. Non-step clocks between the steps of a pattern do not break it, and the mode changes only on a step.
- R10: A pattern with a wrong fifth step changes nothing. A valid pattern that follows extra leading steps still matches on its own fifth step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | One-clock strobe per rising edge of the serial shift clock |
| enable_i | input | 1 | Output blank pin level, 1 = outputs forced off |
| latch_i | input | 1 | Latch pin level, 1 = load |
| shift_data_i | input | CH_W | Parallel contents of the neighbouring shift register |
| special_mode_o | output | 1 | 1 while in special mode |
| latched_o | output | CH_W | Output data latch contents |
| drive_o | output | CH_W | Channel drive, latch data gated by the blank pin |
| bright_load_o | output | 1 | Load strobe for the brightness register in special mode |

## Verification
The assertions assume that `enable_i`, `latch_i` and `step_i` are synchronous to `clk_i`. They also assume that a step that completes a pattern carries a low latch level, so that a load never falls on the same edge as a clear. The stimulus changes every input only on the falling clock edge, sets `latch_i` high only on the clocks where a load or a blocked load is intended, and places its gap cycles between the steps of a pattern rather than inside any single sample.

// File: rtl/led_mode_pkg.sv
package led_mode_pkg;

    typedef enum logic [0:0] {
        MODE_NORMAL  = 1'b0,
        MODE_SPECIAL = 1'b1
    } mode_e;

    typedef struct packed {
        logic en;
        logic lat;
    } ctl_smp_t;

    // Signature bit k belongs to step k+1 of the five-step window.
    localparam int unsigned SIG_LEN_DEF = 5;
    localparam logic [SIG_LEN_DEF-1:0] SPC_EN_DEF  = 5'b11101;
    localparam logic [SIG_LEN_DEF-1:0] SPC_LAT_DEF = 5'b01000;
    localparam logic [SIG_LEN_DEF-1:0] NRM_EN_DEF  = 5'b11101;
    localparam logic [SIG_LEN_DEF-1:0] NRM_LAT_DEF = 5'b00000;

endpackage

// File: rtl/led_mode_history.sv
module led_mode_history
    import led_mode_pkg::*;
#(
    parameter int unsigned SEQ_LEN = 5,
    parameter int unsigned FW      = $clog2(SEQ_LEN)
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         step_i,
    input  ctl_smp_t                     smp_i,
    output ctl_smp_t [SEQ_LEN-2:0]       hist_o,
    output logic     [FW-1:0]            fill_o
);

    localparam int unsigned TOP = SEQ_LEN - 2;
    localparam logic [FW-1:0] FILL_MAX = FW'(SEQ_LEN - 1);

    ctl_smp_t [SEQ_LEN-2:0] hist_q;
    logic     [FW-1:0]      fill_q;

    // Index 0 holds the oldest sample, TOP the newest.
    for (genvar k = 0; k <= TOP; k++) begin : g_slot
        if (k == TOP) begin : g_head
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    hist_q[k] <= '0;
                end else if (step_i) begin
                    hist_q[k] <= smp_i;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    hist_q[k] <= '0;
                end else if (step_i) begin
                    hist_q[k] <= hist_q[k+1];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fill_q <= '0;
        end else if (step_i && (fill_q != FILL_MAX)) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    assign hist_o = hist_q;
    assign fill_o = fill_q;

endmodule

// File: rtl/led_mode_match.sv
module led_mode_match
    import led_mode_pkg::*;
#(
    parameter int unsigned    WIN     = 5,
    parameter int unsigned    FW      = 3,
    parameter int unsigned    NEED    = 4,
    parameter logic [WIN-1:0] SIG_EN  = '0,
    parameter logic [WIN-1:0] SIG_LAT = '0
) (
    input  ctl_smp_t [WIN-1:0] win_i,
    input  logic     [FW-1:0]  fill_i,
    output logic               hit_o
);

    logic [WIN-1:0] eq;

    for (genvar k = 0; k < WIN; k++) begin : g_cmp
        assign eq[k] = (win_i[k].en == SIG_EN[k]) && (win_i[k].lat == SIG_LAT[k]);
    end

    assign hit_o = (&eq) && (fill_i >= FW'(NEED));

endmodule

// File: rtl/led_mode_fsm.sv
module led_mode_fsm
    import led_mode_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic step_i,
    input  logic spc_hit_i,
    input  logic nrm_hit_i,
    output logic special_o,
    output logic clear_o
);

    mode_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= MODE_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    // ENTER, RETURN, REFRESH and HOLD transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NORMAL: begin
                if (step_i && spc_hit_i) begin
                    state_d = MODE_SPECIAL;
                end
            end
            MODE_SPECIAL: begin
                if (step_i && nrm_hit_i) begin
                    state_d = MODE_NORMAL;
                end
            end
            default: state_d = MODE_NORMAL;
        endcase
    end

    always_comb begin
        special_o = (state_q == MODE_SPECIAL);
        clear_o   = step_i && nrm_hit_i;
    end

endmodule

// File: rtl/led_mode_latch.sv
module led_mode_latch #(
    parameter int unsigned CH_W = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            load_i,
    input  logic            clear_i,
    input  logic            enable_i,
    input  logic [CH_W-1:0] data_i,
    output logic [CH_W-1:0] latched_o,
    output logic [CH_W-1:0] drive_o
);

    logic [CH_W-1:0] data_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            data_q <= '0;
        end else if (clear_i) begin
            data_q <= '0;
        end else if (load_i) begin
            data_q <= data_i;
        end
    end

    always_comb begin
        drive_o = enable_i ? '0 : data_q;
    end

    assign latched_o = data_q;

endmodule

// File: rtl/led_mode_seq.sv
module led_mode_seq
    import led_mode_pkg::*;
#(
    parameter int unsigned          CH_W    = 8,
    parameter int unsigned          SEQ_LEN = SIG_LEN_DEF,
    parameter logic [SEQ_LEN-1:0]   SPC_EN  = SPC_EN_DEF,
    parameter logic [SEQ_LEN-1:0]   SPC_LAT = SPC_LAT_DEF,
    parameter logic [SEQ_LEN-1:0]   NRM_EN  = NRM_EN_DEF,
    parameter logic [SEQ_LEN-1:0]   NRM_LAT = NRM_LAT_DEF
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            step_i,
    input  logic            enable_i,
    input  logic            latch_i,
    input  logic [CH_W-1:0] shift_data_i,
    output logic            special_mode_o,
    output logic [CH_W-1:0] latched_o,
    output logic [CH_W-1:0] drive_o,
    output logic            bright_load_o
);

    localparam int unsigned FW        = $clog2(SEQ_LEN);
    localparam int unsigned GUARD_LEN = SEQ_LEN - 2;

    ctl_smp_t                 cur_smp;
    ctl_smp_t [SEQ_LEN-2:0]   hist_w;
    ctl_smp_t [SEQ_LEN-1:0]   win_full;
    ctl_smp_t [GUARD_LEN-1:0] win_guard;
    logic     [FW-1:0]        fill_w;
    logic                     spc_hit_w;
    logic                     nrm_hit_w;
    logic                     guard_w;
    logic                     clear_w;
    logic                     load_w;

    assign cur_smp   = '{en: enable_i, lat: latch_i};
    assign win_full  = {cur_smp, hist_w};
    assign win_guard = hist_w[SEQ_LEN-2:1];

    led_mode_history #(.SEQ_LEN(SEQ_LEN), .FW(FW)) u_hist (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (step_i),
        .smp_i  (cur_smp),
        .hist_o (hist_w),
        .fill_o (fill_w)
    );

    led_mode_match #(
        .WIN(SEQ_LEN), .FW(FW), .NEED(SEQ_LEN - 1),
        .SIG_EN(SPC_EN), .SIG_LAT(SPC_LAT)
    ) u_spc_match (
        .win_i  (win_full),
        .fill_i (fill_w),
        .hit_o  (spc_hit_w)
    );

    led_mode_match #(
        .WIN(SEQ_LEN), .FW(FW), .NEED(SEQ_LEN - 1),
        .SIG_EN(NRM_EN), .SIG_LAT(NRM_LAT)
    ) u_nrm_match (
        .win_i  (win_full),
        .fill_i (fill_w),
        .hit_o  (nrm_hit_w)
    );

    // Entry guard: stored steps so far match the special prefix.
    led_mode_match #(
        .WIN(GUARD_LEN), .FW(FW), .NEED(GUARD_LEN),
        .SIG_EN(SPC_EN[GUARD_LEN-1:0]), .SIG_LAT(SPC_LAT[GUARD_LEN-1:0])
    ) u_guard_match (
        .win_i  (win_guard),
        .fill_i (fill_w),
        .hit_o  (guard_w)
    );

    led_mode_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_i    (step_i),
        .spc_hit_i (spc_hit_w),
        .nrm_hit_i (nrm_hit_w),
        .special_o (special_mode_o),
        .clear_o   (clear_w)
    );

    assign load_w        = latch_i && !special_mode_o && !guard_w;
    assign bright_load_o = latch_i &&  special_mode_o && !guard_w;

    led_mode_latch #(.CH_W(CH_W)) u_latch (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (load_w),
        .clear_i   (clear_w),
        .enable_i  (enable_i),
        .data_i    (shift_data_i),
        .latched_o (latched_o),
        .drive_o   (drive_o)
    );

endmodule

// File: rtl/led_mode_seq_chk.sv
module led_mode_seq_chk #(
    parameter int unsigned CH_W = 8
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            step_i,
    input logic            enable_i,
    input logic            latch_i,
    input logic [CH_W-1:0] shift_data_i,
    input logic            special_mode_o,
    input logic [CH_W-1:0] latched_o,
    input logic [CH_W-1:0] drive_o,
    input logic            bright_load_o,
    input logic            guard_i,
    input logic            spc_hit_i,
    input logic            nrm_hit_i
);

    assert_reset_state_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (!special_mode_o && latched_o == '0));

    assert_normal_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (latch_i && !special_mode_o && !guard_i) |=> latched_o == $past(shift_data_i));

    assert_blank_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        enable_i |-> drive_o == '0);

    assert_hits_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({spc_hit_i, nrm_hit_i}));

    assert_return_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(special_mode_o) |-> latched_o == '0);

    assert_guard_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (guard_i && latch_i && !special_mode_o) |=> $stable(latched_o));

    assert_special_keeps_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        special_mode_o |=> (latched_o == $past(latched_o) || latched_o == '0));

    assert_bright_only_special_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bright_load_o |-> special_mode_o);

    assert_mode_on_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> $stable(special_mode_o));

endmodule

bind led_mode_seq led_mode_seq_chk #(.CH_W(CH_W)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .step_i         (step_i),
    .enable_i       (enable_i),
    .latch_i        (latch_i),
    .shift_data_i   (shift_data_i),
    .special_mode_o (special_mode_o),
    .latched_o      (latched_o),
    .drive_o        (drive_o),
    .bright_load_o  (bright_load_o),
    .guard_i        (guard_w),
    .spc_hit_i      (spc_hit_w),
    .nrm_hit_i      (nrm_hit_w)
);

// File: tb/led_mode_seq_tb_top.sv
`timescale 1ns/1ps
module led_mode_seq_tb_top;

    localparam int CH_W  = 8;
    localparam int NVEC  = 32;
    localparam int LIMIT = 200000;

    typedef struct packed {
        logic       en;
        logic       lat;
        logic       stp;
        logic [7:0] din;
        logic       mode;
        logic       bl;
        logic [7:0] latq;
        logic [7:0] drv;
        logic [7:0] req;
    } vec_t;

    // en, lat, stp, din | mode, bl, latched, drive | requirement
    localparam vec_t VEC [NVEC] = '{
        '{1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00,8'h00, 8'd1},  // R1 idle
        '{1'b0,1'b1,1'b0,8'hA5, 1'b0,1'b0,8'hA5,8'hA5, 8'd2},  // R2 load
        '{1'b1,1'b0,1'b0,8'hFF, 1'b0,1'b0,8'hA5,8'h00, 8'd3},  // R3 blank
        '{1'b1,1'b0,1'b1,8'hFF, 1'b0,1'b0,8'hA5,8'h00, 8'd4},  // R4 step 1
        '{1'b0,1'b0,1'b1,8'hFF, 1'b0,1'b0,8'hA5,8'hA5, 8'd4},  // R4 step 2
        '{1'b0,1'b0,1'b0,8'hFF, 1'b0,1'b0,8'hA5,8'hA5, 8'd9},  // R9 gap
        '{1'b1,1'b0,1'b1,8'hFF, 1'b0,1'b0,8'hA5,8'h00, 8'd4},  // R4 step 3
        '{1'b1,1'b1,1'b1,8'h3C, 1'b0,1'b0,8'hA5,8'h00, 8'd7},  // R7 guarded
        '{1'b1,1'b0,1'b1,8'h3C, 1'b1,1'b0,8'hA5,8'h00, 8'd4},  // R4 enter
        '{1'b0,1'b1,1'b0,8'h3C, 1'b1,1'b1,8'hA5,8'hA5, 8'd8},  // R8 bright
        '{1'b1,1'b0,1'b1,8'h3C, 1'b1,1'b0,8'hA5,8'h00, 8'd5},
        '{1'b0,1'b0,1'b1,8'h3C, 1'b1,1'b0,8'hA5,8'hA5, 8'd5},
        '{1'b1,1'b0,1'b1,8'h3C, 1'b1,1'b0,8'hA5,8'h00, 8'd5},
        '{1'b1,1'b0,1'b1,8'h3C, 1'b1,1'b0,8'hA5,8'h00, 8'd5},
        '{1'b1,1'b0,1'b1,8'h3C, 1'b0,1'b0,8'h00,8'h00, 8'd5},  // R5 return
        '{1'b0,1'b1,1'b0,8'hC3, 1'b0,1'b0,8'hC3,8'hC3, 8'd2},  // R2 reload
        '{1'b1,1'b0,1'b1,8'hC3, 1'b0,1'b0,8'hC3,8'h00, 8'd6},
        '{1'b0,1'b0,1'b1,8'hC3, 1'b0,1'b0,8'hC3,8'hC3, 8'd6},
        '{1'b1,1'b0,1'b1,8'hC3, 1'b0,1'b0,8'hC3,8'h00, 8'd6},
        '{1'b1,1'b0,1'b1,8'hC3, 1'b0,1'b0,8'hC3,8'h00, 8'd6},
        '{1'b1,1'b0,1'b1,8'hC3, 1'b0,1'b0,8'h00,8'h00, 8'd6},  // R6 refresh
        '{1'b1,1'b0,1'b1,8'h5A, 1'b0,1'b0,8'h00,8'h00, 8'd10},
        '{1'b0,1'b0,1'b1,8'h5A, 1'b0,1'b0,8'h00,8'h00, 8'd10},
        '{1'b1,1'b0,1'b1,8'h5A, 1'b0,1'b0,8'h00,8'h00, 8'd10},
        '{1'b1,1'b1,1'b1,8'h5A, 1'b0,1'b0,8'h00,8'h00, 8'd7},  // R7 guarded
        '{1'b0,1'b0,1'b1,8'h5A, 1'b0,1'b0,8'h00,8'h00, 8'd10}, // R10 bad 5th
        '{1'b1,1'b0,1'b1,8'h5A, 1'b0,1'b0,8'h00,8'h00, 8'd10}, // R10 extra
        '{1'b1,1'b0,1'b1,8'h5A, 1'b0,1'b0,8'h00,8'h00, 8'd10},
        '{1'b0,1'b0,1'b1,8'h5A, 1'b0,1'b0,8'h00,8'h00, 8'd10},
        '{1'b1,1'b0,1'b1,8'h5A, 1'b0,1'b0,8'h00,8'h00, 8'd10},
        '{1'b1,1'b1,1'b1,8'h5A, 1'b0,1'b0,8'h00,8'h00, 8'd7},
        '{1'b1,1'b0,1'b1,8'h5A, 1'b1,1'b0,8'h00,8'h00, 8'd10}  // R10 match
    };

    logic            clk_i = 1'b0;
    logic            rst_ni = 1'b0;
    logic            step_i = 1'b0;
    logic            enable_i = 1'b1;
    logic            latch_i = 1'b0;
    logic [CH_W-1:0] shift_data_i = '0;
    logic            special_mode_o;
    logic [CH_W-1:0] latched_o;
    logic [CH_W-1:0] drive_o;
    logic            bright_load_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk_i = ~clk_i;

    led_mode_seq #(.CH_W(CH_W)) dut_i (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .step_i         (step_i),
        .enable_i       (enable_i),
        .latch_i        (latch_i),
        .shift_data_i   (shift_data_i),
        .special_mode_o (special_mode_o),
        .latched_o      (latched_o),
        .drive_o        (drive_o),
        .bright_load_o  (bright_load_o)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        // R1: reset state
        check("R1", "mode", {7'd0, special_mode_o}, 8'h00);
        check("R1", "latched", latched_o, 8'h00);
        check("R1", "drive", drive_o, 8'h00);
        rst_ni = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk_i);
            enable_i     = VEC[i].en;
            latch_i      = VEC[i].lat;
            step_i       = VEC[i].stp;
            shift_data_i = VEC[i].din;
            @(posedge clk_i);
            #1;
            check($sformatf("R%0d row %0d", VEC[i].req, i), "mode",
                  {7'd0, special_mode_o}, {7'd0, VEC[i].mode});
            check($sformatf("R%0d row %0d", VEC[i].req, i), "bright",
                  {7'd0, bright_load_o}, {7'd0, VEC[i].bl});
            check($sformatf("R%0d row %0d", VEC[i].req, i), "latched",
                  latched_o, VEC[i].latq);
            check($sformatf("R%0d row %0d", VEC[i].req, i), "drive",
                  drive_o, VEC[i].drv);
        end

        // R8: special mode, latch high with new data keeps the latch
        @(negedge clk_i);
        step_i = 1'b0; enable_i = 1'b0; latch_i = 1'b1; shift_data_i = 8'h77;
        @(posedge clk_i);
        #1;
        check("R8", "latched", latched_o, 8'h00);
        check("R8", "bright", {7'd0, bright_load_o}, 8'h01);

        // R1: reset applied while in special mode
        @(negedge clk_i);
        latch_i = 1'b0;
        rst_ni  = 1'b0;
        @(posedge clk_i);
        #1;
        check("R1", "mode after reset", {7'd0, special_mode_o}, 8'h00);
        check("R1", "latched after reset", latched_o, 8'h00);

        // R2: load works again after reset release
        @(negedge clk_i);
        rst_ni = 1'b1; latch_i = 1'b1; shift_data_i = 8'h81;
        @(posedge clk_i);
        #1;
        check("R2", "latched after reset", latched_o, 8'h81);
        check("R3", "drive enable low", drive_o, 8'h81);
        @(negedge clk_i);
        latch_i = 1'b0; enable_i = 1'b1;
        #1;
        check("R3", "drive blanked", drive_o, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk_i);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule